// File: doc/BRIEF.md
# Serial Output Unscrambler with Inverse Scaling

This block sits at the tail of a two-stage 64-point transform built from 8-point kernels. The second kernel delivers its results as groups of eight complex samples, one group per clock. Each group is written in a single cycle into a shift bank of 57 complex entries. Element i of a group lands in slot 8i through a fixed connection. The bank moves down by one slot on every clock. Because of this, the samples leave slot 0 in natural order, index 8i+g for element i of group g, and no reorder memory or multiplexer is needed.

A start pulse opens a 64-sample output burst. A 6-bit index counter follows the burst, and a valid flag stays high for exactly 64 cycles. The transform direction is latched when the burst starts. In inverse mode each outgoing sample has its real and imaginary parts exchanged, and both parts are then divided by 64 with an arithmetic right shift. In forward mode samples leave unchanged. The data width (16 bits per part) and the scaling shift (6) are package constants. The group size and the group count are parameters of the top module.

Top module: `serial_unscrambler`

## Requirements
- R1: While reset is active, out_valid is 0, out_idx is 0 and out_re and out_im are 0.
- R2: On a clock edge with grp_wr high, element i of the group is written to bank slot 8i for i = 0..7. Element i is carried on bits [16i+15:16i] of grp_re and grp_im.
- R3: On every edge the bank shifts down one slot and the top slot refills with zero. out_re and out_im always present slot 0 after formatting, including outside a burst.
- R4: When grp_wr is high, the group data written to slots 8i override the values that would have shifted into those slots.
- R5: Eight groups are written on consecutive edges, the first on the edge that samples burst_go. Then the n-th valid output cycle (n = 0..63) carries sample 8i+g, where n = 8i+g.
- R6: When idle, burst_go sampled high raises out_valid after that edge with out_idx 0. Without burst_go, out_valid stays low.
- R7: During a burst, out_idx steps by one per cycle from 0 to 63 and out_valid stays high for 64 cycles.
- R8: After the cycle with out_idx 63, out_idx returns to 0 and out_valid falls on the same edge.
- R9: burst_go asserted during a burst is ignored: the index keeps counting and the burst still ends after 64 cycles.
- R10: In forward mode (inv_mode 0 at burst start), out_re and out_im equal the stored real and imaginary parts.
- R11: In inverse mode (inv_mode 1 at burst start), out_re is the stored imaginary part and out_im is the stored real part. Each is arithmetically shifted right by 6, which gives floor division by 64.
- R12: inv_mode is sampled only on the edge that starts a burst. Changes to it during the burst have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_wr | input | 1 | Write the presented group into the tap slots |
| grp_re | input | 128 | Real parts of the group, element i at bits 16i+15:16i |
| grp_im | input | 128 | Imaginary parts of the group, same packing |
| burst_go | input | 1 | Start of a 64-sample output burst |
| inv_mode | input | 1 | 1 selects inverse formatting, 0 forward |
| out_valid | output | 1 | High while burst samples are presented |
| out_idx | output | 6 | Index of the sample currently presented |
| out_re | output | 16 | Real part of the formatted slot-0 sample |
| out_im | output | 16 | Imaginary part of the formatted slot-0 sample |

## Verification
The hardest case to reach is a group write that lands on slots already holding live data, because in normal operation the writes line up exactly with empty slots. The stimulus writes one group, idles seven cycles so that its elements sit one slot above the taps, and then writes a second group. It then checks that only the second group's values ever reach slot 0. A burst is also run in which the mode input flips and a second start pulse arrives partway through. This shows that the latched direction and the running count are both unaffected.

// File: rtl/unscr_pkg.sv
package unscr_pkg;
  parameter int DW       = 16;
  parameter int SCALE_SH = 6;

  typedef struct packed {
    logic signed [DW-1:0] re;
    logic signed [DW-1:0] im;
  } cpx_t;

  // Inverse formatting: exchange parts, then arithmetic shift (R11)
  function automatic cpx_t fmt_sample(input cpx_t s, input logic inv);
    cpx_t r;
    if (inv) begin
      r.re = s.im >>> SCALE_SH;
      r.im = s.re >>> SCALE_SH;
    end else begin
      r = s;
    end
    return r;
  endfunction
endpackage

// File: rtl/unscr_bank.sv
module unscr_bank
  import unscr_pkg::*;
#(
  parameter int PTS    = 8,
  parameter int GROUPS = 8,
  localparam int DEPTH = GROUPS * (PTS - 1) + 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  cpx_t grp [PTS],
  output cpx_t head,
  output cpx_t slot1
);
  cpx_t slot_w [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    cpx_t above;
    cpx_t nxt;
    cpx_t q;

    // R3: top slot refills with zero, others take the slot above
    if (k == DEPTH - 1) begin : g_top
      assign above = '0;
    end else begin : g_mid
      assign above = slot_w[k+1];
    end

    // R2/R4: tap slots at multiples of GROUPS take the group word first
    if (k % GROUPS == 0) begin : g_tap
      assign nxt = wr ? grp[k/GROUPS] : above;
    end else begin : g_pass
      assign nxt = above;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
    end

    assign slot_w[k] = q;
  end

  assign head  = slot_w[0];
  assign slot1 = slot_w[1];
endmodule

// File: rtl/unscr_ctrl.sv
module unscr_ctrl #(
  parameter int LEN = 64,
  localparam int CW = $clog2(LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          inv_in,
  output logic          busy,
  output logic [CW-1:0] idx,
  output logic          inv_q,
  output logic          start_ev,
  output logic          last_ev
);
  // R6/R9: a start only counts when idle
  assign start_ev = go && !busy;
  // R8: terminal count of the burst
  assign last_ev  = busy && (idx == CW'(LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      idx   <= '0;
      inv_q <= 1'b0;
    end else if (start_ev) begin
      busy  <= 1'b1;
      idx   <= '0;
      inv_q <= inv_in;          // R12: direction latched at start only
    end else if (last_ev) begin
      busy  <= 1'b0;
      idx   <= '0;
    end else if (busy) begin
      idx   <= idx + 1'b1;      // R7
    end
  end
endmodule

// File: rtl/unscr_fmt.sv
module unscr_fmt
  import unscr_pkg::*;
(
  input  cpx_t sample,
  input  logic inv,
  output cpx_t result
);
  // R10/R11
  always_comb result = fmt_sample(sample, inv);
endmodule

// File: rtl/serial_unscrambler.sv
module serial_unscrambler
  import unscr_pkg::*;
#(
  parameter int PTS    = 8,
  parameter int GROUPS = 8,
  localparam int BURST = PTS * GROUPS,
  localparam int CW    = $clog2(BURST)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grp_wr,
  input  logic [PTS*DW-1:0] grp_re,
  input  logic [PTS*DW-1:0] grp_im,
  input  logic              burst_go,
  input  logic              inv_mode,
  output logic              out_valid,
  output logic [CW-1:0]     out_idx,
  output logic [DW-1:0]     out_re,
  output logic [DW-1:0]     out_im
);
  cpx_t grp [PTS];
  cpx_t head;
  cpx_t slot1;
  cpx_t formatted;
  logic inv_lat;
  logic start_ev;
  logic last_ev;

  // Unpack the flat group buses, element i at bits [DW*i +: DW] (R2)
  for (genvar i = 0; i < PTS; i++) begin : g_unpack
    assign grp[i].re = grp_re[i*DW +: DW];
    assign grp[i].im = grp_im[i*DW +: DW];
  end

  unscr_bank #(.PTS(PTS), .GROUPS(GROUPS)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (grp_wr),
    .grp   (grp),
    .head  (head),
    .slot1 (slot1)
  );

  unscr_ctrl #(.LEN(BURST)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (burst_go),
    .inv_in   (inv_mode),
    .busy     (out_valid),
    .idx      (out_idx),
    .inv_q    (inv_lat),
    .start_ev (start_ev),
    .last_ev  (last_ev)
  );

  unscr_fmt u_fmt (
    .sample (head),
    .inv    (inv_lat),
    .result (formatted)
  );

  assign out_re = formatted.re;
  assign out_im = formatted.im;
endmodule

// File: rtl/unscr_chk.sv
module unscr_chk
  import unscr_pkg::*;
#(
  parameter int LEN = 64,
  localparam int CW = $clog2(LEN)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          grp_wr,
  input logic          burst_go,
  input logic          out_valid,
  input logic [CW-1:0] out_idx,
  input logic          inv_lat,
  input cpx_t          head,
  input cpx_t          slot1,
  input cpx_t          grp0
);
  AST_GO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && burst_go) |=> (out_valid && out_idx == '0)); // R6
  AST_IDLE_STAY: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !burst_go) |=> !out_valid); // R6
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_idx != CW'(LEN - 1)) |=> (out_valid && out_idx == $past(out_idx) + 1'b1)); // R7
  AST_BURST_END: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_idx == CW'(LEN - 1)) |=> (!out_valid && out_idx == '0)); // R8
  AST_IDLE_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_idx == '0); // R8
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> (!out_valid || inv_lat == $past(inv_lat))); // R12
  AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_wr |=> head == $past(slot1)); // R3
  AST_TAP_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    grp_wr |=> head == $past(grp0)); // R4
endmodule

bind serial_unscrambler unscr_chk #(.LEN(BURST)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .grp_wr    (grp_wr),
  .burst_go  (burst_go),
  .out_valid (out_valid),
  .out_idx   (out_idx),
  .inv_lat   (inv_lat),
  .head      (head),
  .slot1     (slot1),
  .grp0      (grp[0])
);

// File: tb/sim_serial_unscrambler.sv
`timescale 1ns/1ps
module sim_serial_unscrambler;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         grp_wr = 1'b0;
  logic [127:0] grp_re = '0;
  logic [127:0] grp_im = '0;
  logic         burst_go = 1'b0;
  logic         inv_mode = 1'b0;
  logic         out_valid;
  logic [5:0]   out_idx;
  logic [15:0]  out_re;
  logic [15:0]  out_im;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  serial_unscrambler u0 (
    .clk(clk), .rst_n(rst_n), .grp_wr(grp_wr), .grp_re(grp_re), .grp_im(grp_im),
    .burst_go(burst_go), .inv_mode(inv_mode), .out_valid(out_valid),
    .out_idx(out_idx), .out_re(out_re), .out_im(out_im)
  );

  function automatic int re_of(input int n, input int seed);
    return ((n * 2731 + seed * 977) % 65536) - 32768;
  endfunction
  function automatic int im_of(input int n, input int seed);
    return ((n * 4093 + seed * 1553 + 12345) % 65536) - 32768;
  endfunction
  // floor division by 64, written without shifts
  function automatic int floor64(input int x);
    if (x >= 0) return x / 64;
    return -((-x + 63) / 64);
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load_elem(input int i, input int re, input int im);
    grp_re[i*16 +: 16] = 16'(re);
    grp_im[i*16 +: 16] = 16'(im);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "valid in reset", int'(out_valid), 0);
    chk(out_idx == 6'd0, "R1", "idx in reset", int'(out_idx), 0);
    chk(out_re == 16'd0 && out_im == 16'd0, "R1", "data in reset", int'(out_re), 0);
    rst_n = 1'b1;
    step();
  endtask

  // single group, no burst: elements surface every 8 shifts, gaps are zero
  task automatic t_single_group();
    for (int i = 0; i < 8; i++) load_elem(i, re_of(i, 3), im_of(i, 3));
    grp_wr = 1'b1;
    for (int t = 0; t <= 57; t++) begin
      step();
      grp_wr = 1'b0;
      if (t == 0)  chk(int'($signed(out_re)) == re_of(0, 3), "R2", "slot0 element", int'($signed(out_re)), re_of(0, 3));
      if (t == 1)  chk(out_re == 16'd0 && out_im == 16'd0, "R3", "gap slot zero", int'($signed(out_re)), 0);
      if (t == 8)  chk(int'($signed(out_im)) == im_of(1, 3), "R2", "slot8 element", int'($signed(out_im)), im_of(1, 3));
      if (t == 56) chk(int'($signed(out_re)) == re_of(7, 3), "R2", "slot56 element", int'($signed(out_re)), re_of(7, 3));
      if (t == 57) chk(out_re == 16'd0 && out_im == 16'd0, "R3", "top refill zero", int'($signed(out_re)), 0);
      if (t == 30) chk(out_valid == 1'b0, "R6", "no burst without start", int'(out_valid), 0);
    end
  endtask

  // second group written over live data one slot above the taps
  task automatic t_priority();
    for (int t = 0; t <= 16; t++) begin
      if (t == 0 || t == 8) begin
        for (int i = 0; i < 8; i++) load_elem(i, re_of(i, (t == 0) ? 5 : 6), im_of(i, (t == 0) ? 5 : 6));
        grp_wr = 1'b1;
      end
      step();
      grp_wr = 1'b0;
      if (t == 8)  chk(int'($signed(out_re)) == re_of(0, 6), "R4", "new group wins slot0", int'($signed(out_re)), re_of(0, 6));
      if (t == 9)  chk(out_re == 16'd0 && out_im == 16'd0, "R4", "old data dropped", int'($signed(out_re)), 0);
      if (t == 16) chk(int'($signed(out_im)) == im_of(1, 6), "R4", "new group wins slot8", int'($signed(out_im)), im_of(1, 6));
    end
    repeat (60) step();
  endtask

  task automatic run_frame(input int seed, input bit inv, input int flip_at, input int go_at, input string dtag);
    for (int n = 0; n < 64; n++) begin
      grp_wr   = (n < 8);
      burst_go = (n == 0) || (n == go_at);
      inv_mode = (flip_at >= 0 && n >= flip_at) ? ~inv : inv;
      if (n < 8)
        for (int i = 0; i < 8; i++) load_elem(i, re_of(8*i + n, seed), im_of(8*i + n, seed));
      step();
      begin
        int er, ei;
        er = inv ? floor64(im_of(n, seed)) : re_of(n, seed);
        ei = inv ? floor64(re_of(n, seed)) : im_of(n, seed);
        chk(out_valid == 1'b1, (n == 0) ? "R6" : "R7", "valid in burst", int'(out_valid), 1);
        chk(int'(out_idx) == n, (go_at >= 0 && n > go_at) ? "R9" : "R7", "index", int'(out_idx), n);
        chk(int'($signed(out_re)) == er, dtag, "real part", int'($signed(out_re)), er);
        chk(int'($signed(out_im)) == ei, dtag, "imag part", int'($signed(out_im)), ei);
      end
    end
    grp_wr = 1'b0;
    burst_go = 1'b0;
    step();
    chk(out_valid == 1'b0, "R8", "valid after 64", int'(out_valid), 0);
    chk(out_idx == 6'd0, "R8", "idx cleared", int'(out_idx), 0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_single_group();
    t_priority();
    run_frame(1, 1'b0, -1, -1, "R5 R10");
    run_frame(2, 1'b1, -1, -1, "R11");
    run_frame(4, 1'b1, 10, 20, "R12");
    run_frame(7, 1'b0, 33, -1, "R12 fwd");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule